// File: doc/BRIEF.md
# Multiplexed Display Refresh Controller

This block holds the contents of a multiplexed numeric display in a sixteen-location, eight-bit display memory. It drives one digit at a time onto a pair of nibble outputs, in step with a scan counter that steps through the digit positions. A host reaches the memory over a single byte-wide input stream. Each beat on that stream is a command, a data write or a data read request. Read data returns on a separate output stream. Segment decoding and the drive electronics sit outside the block.

Commands choose between an 8-digit and a 16-digit display, and between two entry orders. In left entry, each byte lands at the address held in a pointer register. In right entry, the digits scroll toward position 0 and the new byte lands at the rightmost position. Further commands set the pointer and its auto-increment flag, protect either nibble of the memory from host writes, force either nibble of the outputs dark, and wipe the memory.

Back-pressure rules: an input beat is taken in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low from the cycle after an accepted read until the read result has been taken. A read result is offered with `rd_valid`, held with `rd_data` unchanged, and taken in a cycle where `rd_ready` is high.

Top module: `disp_refresh_ctrl`

## Requirements
- R1: After reset, `scan_idx` is 0, `rd_valid` is 0, `in_ready` is 1, and both nibble outputs are 0, because the memory is cleared.
- R2: `in_kind` encodes the beat type: 00 is a command, 01 is a data write, 10 is a read request, and 11 is ignored. A command's opcode sits in `in_byte[7:5]`. Opcode 000 sets the display mode from bits 1:0, where bit 0 set selects 16 digits and bit 1 set selects right entry. Reset leaves 8 digits with left entry.
- R3: Opcode 100 loads the pointer from `in_byte[3:0]` and the auto-increment flag from `in_byte[4]`. The pointer is used modulo N, where N is the digit count. In left entry, a write stores its byte at the pointer. If auto-increment is on, the pointer then moves to (pointer+1) mod N.
- R4: In right entry, a write moves each location i (for i from 0 to N-2) to hold the old contents of location i+1. The new byte goes to location N-1, and the pointer does not move. Locations at N and above are untouched.
- R5: Opcode 101 sets four flags: bit 3 protects the upper nibble, bit 2 protects the lower nibble, bit 1 blanks the upper nibble output, and bit 0 blanks the lower nibble output. A protected nibble of the written location keeps its previous value.
- R6: A read request makes `rd_valid` high in the next cycle, with `rd_data` equal to the memory at the pointer. If auto-increment is on, the pointer then advances mod N. `rd_data` and `rd_valid` hold until `rd_ready`, and `in_ready` is low while `rd_valid` is high.
- R7: Each digit slot lasts SCAN_DIV cycles. `scan_idx` counts 0, 1, … N-1 and then wraps to 0.
- R8: `disp_blank` is high in the first cycle of every slot, and both nibble outputs are 0 in that cycle. In the other cycles the outputs carry the upper and lower nibbles of the memory at `scan_idx`.
- R9: While a blanking flag is set, the matching nibble output stays 0.
- R10: Opcode 110 sets all sixteen locations to 0 and the pointer to 0.
- R11: Opcodes 001, 010, 011 and 111, and beats with kind 11, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be taken |
| in_kind | input | 2 | Beat type: command, write, read |
| in_byte | input | 8 | Command or write data |
| rd_valid | output | 1 | Read result valid |
| rd_ready | input | 1 | Read result taken |
| rd_data | output | 8 | Read result |
| scan_idx | output | 4 | Digit position being driven |
| disp_blank | output | 1 | Display off during a digit change |
| seg_hi | output | 4 | Upper nibble of the current digit |
| seg_lo | output | 4 | Lower nibble of the current digit |

## Verification
The assertions check several behaviours on every cycle:
- A pending read result stays put while it is held off.
- `scan_idx` only steps by one or wraps to zero.
- Every change of digit comes with `disp_blank`, and the outputs are dark whenever `disp_blank` is high.
- A blanking command or a clear darkens the outputs from the next cycle.

Some behaviours only the bench scenarios can show, because they need a memory model:
- The right-entry scroll and the nibble merge under write protection.
- Pointer wrap at 8 versus 16 digits.
- Slot length and wrap point of the scan.
- That undefined opcodes leave the stored digits alone.

// File: rtl/disp_refresh_pkg.sv
package disp_refresh_pkg;
  localparam int DIGITS_MAX = 16;
  localparam int AW         = $clog2(DIGITS_MAX);

  typedef enum logic [1:0] {
    K_CMD = 2'b00,
    K_WR  = 2'b01,
    K_RD  = 2'b10,
    K_NOP = 2'b11
  } kind_e;

  typedef enum logic [2:0] {
    OP_MODE = 3'b000,
    OP_PTR  = 3'b100,
    OP_NIB  = 3'b101,
    OP_CLR  = 3'b110
  } op_e;

  typedef struct packed {
    logic       set_mode;
    logic       set_ptr;
    logic       set_nib;
    logic       clr;
    logic [4:0] arg;
  } cmd_t;
endpackage

// File: rtl/dr_cmd_decode.sv
module dr_cmd_decode
  import disp_refresh_pkg::*;
(
  input  logic       take,
  input  logic [7:0] cmd_byte,
  output cmd_t       cmd
);
  always_comb begin
    cmd     = '0;
    cmd.arg = cmd_byte[4:0];
    if (take) begin
      unique case (cmd_byte[7:5])
        OP_MODE: cmd.set_mode = 1'b1;
        OP_PTR:  cmd.set_ptr  = 1'b1;
        OP_NIB:  cmd.set_nib  = 1'b1;
        OP_CLR:  cmd.clr      = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dr_disp_ram.sv
module dr_disp_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int HW   = W / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic          wr_shift,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] last_idx,
  input  logic [W-1:0]  wr_data,
  input  logic          keep_hi,
  input  logic          keep_lo,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic [AW-1:0] scan_addr,
  output logic [W-1:0]  scan_data
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] tgt;
  logic [W-1:0]  merged;

  assign tgt     = wr_shift ? last_idx : wr_addr;
  assign merged  = {keep_hi ? mem[tgt][W-1:HW] : wr_data[W-1:HW],
                    keep_lo ? mem[tgt][HW-1:0] : wr_data[HW-1:0]};
  assign rd_data   = mem[rd_addr];
  assign scan_data = mem[scan_addr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_loc
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        mem[i] <= '0;
      end else if (wr_en) begin
        if (wr_shift) begin
          if (AW'(i) < last_idx)       mem[i] <= mem[(i + 1) % DEPTH];
          else if (AW'(i) == last_idx) mem[i] <= merged;
        end else if (AW'(i) == wr_addr) begin
          mem[i] <= merged;
        end
      end
    end
  end
endmodule

// File: rtl/dr_scan.sv
module dr_scan #(
  parameter int SCAN_DIV = 4,
  parameter int AW       = 4,
  localparam int DW      = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] last_idx,
  output logic [AW-1:0] idx,
  output logic          slot_start
);
  logic [DW-1:0] div;
  logic          slot_end;

  assign slot_end   = (div == DW'(SCAN_DIV - 1));
  assign slot_start = (div == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div <= '0;
      idx <= '0;
    end else if (slot_end) begin
      div <= '0;
      idx <= (idx >= last_idx) ? '0 : idx + 1'b1;
    end else begin
      div <= div + 1'b1;
    end
  end
endmodule

// File: rtl/disp_refresh_ctrl.sv
module disp_refresh_ctrl
  import disp_refresh_pkg::*;
#(
  parameter int SCAN_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] in_kind,
  input  logic [7:0] in_byte,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  output logic [3:0] scan_idx,
  output logic       disp_blank,
  output logic [3:0] seg_hi,
  output logic [3:0] seg_lo
);
  cmd_t          cmd;
  logic          accept, wr_en, rd_go;
  logic [1:0]    mode;
  logic [AW-1:0] ptr, ptr_eff, last_idx, ram_rd;
  logic          auto_inc, inh_hi, inh_lo, blk_hi, blk_lo;
  logic [7:0]    ram_rd_data, scan_data;

  assign in_ready = !rd_valid;
  assign accept   = in_valid && in_ready;
  assign wr_en    = accept && (in_kind == K_WR);
  assign rd_go    = accept && (in_kind == K_RD);
  assign last_idx = mode[0] ? AW'(DIGITS_MAX - 1) : AW'(DIGITS_MAX / 2 - 1);
  assign ptr_eff  = ptr & last_idx;
  assign ram_rd   = ptr_eff;

  dr_cmd_decode u_dec (
    .take     (accept && (in_kind == K_CMD)),
    .cmd_byte (in_byte),
    .cmd      (cmd)
  );

  dr_disp_ram #(.DEPTH(DIGITS_MAX), .W(8)) u_ram (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cmd.clr),
    .wr_en     (wr_en),
    .wr_shift  (mode[1]),
    .wr_addr   (ptr_eff),
    .last_idx  (last_idx),
    .wr_data   (in_byte),
    .keep_hi   (inh_hi),
    .keep_lo   (inh_lo),
    .rd_addr   (ram_rd),
    .rd_data   (ram_rd_data),
    .scan_addr (scan_idx),
    .scan_data (scan_data)
  );

  dr_scan #(.SCAN_DIV(SCAN_DIV), .AW(AW)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .last_idx   (last_idx),
    .idx        (scan_idx),
    .slot_start (disp_blank)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= 2'b00;
      ptr      <= '0;
      auto_inc <= 1'b0;
      {inh_hi, inh_lo, blk_hi, blk_lo} <= '0;
    end else begin
      if (cmd.set_mode) mode <= cmd.arg[1:0];
      if (cmd.set_nib)  {inh_hi, inh_lo, blk_hi, blk_lo} <= cmd.arg[3:0];
      if (cmd.clr) begin
        ptr <= '0;
      end else if (cmd.set_ptr) begin
        ptr      <= cmd.arg[AW-1:0];
        auto_inc <= cmd.arg[4];
      end else if (auto_inc && (rd_go || (wr_en && !mode[1]))) begin
        ptr <= (ptr_eff + 1'b1) & last_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (rd_go) begin
      rd_valid <= 1'b1;
      rd_data  <= ram_rd_data;
    end else if (rd_valid && rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  assign seg_hi = (disp_blank || blk_hi) ? 4'h0 : scan_data[7:4];
  assign seg_lo = (disp_blank || blk_lo) ? 4'h0 : scan_data[3:0];
endmodule

// File: rtl/disp_refresh_ctrl_chk.sv
module disp_refresh_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [1:0] in_kind,
  input logic [7:0] in_byte,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic [3:0] scan_idx,
  input logic       disp_blank,
  input logic [3:0] seg_hi,
  input logic [3:0] seg_lo
);
  logic cmd_take;
  assign cmd_take = in_valid && in_ready && (in_kind == 2'b00);

  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  assert_scan_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scan_idx) |-> (scan_idx == $past(scan_idx) + 4'd1) || (scan_idx == 4'd0));

  assert_change_blanked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scan_idx) |-> disp_blank);

  assert_blank_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    disp_blank |-> (seg_hi == 4'h0) && (seg_lo == 4'h0));

  assert_nib_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take && (in_byte[7:5] == 3'b101) && in_byte[1] |=> seg_hi == 4'h0);

  assert_clear_dark_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take && (in_byte[7:5] == 3'b110) |=> (seg_hi == 4'h0) && (seg_lo == 4'h0));
endmodule

bind disp_refresh_ctrl disp_refresh_ctrl_chk u_chk (.*);

// File: tb/sim_disp_refresh_ctrl.sv
module sim_disp_refresh_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SCAN_DIV   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_kind = 2'b00;
  logic [7:0] in_byte = 8'h00;
  logic       rd_valid;
  logic       rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic [3:0] scan_idx;
  logic       disp_blank;
  logic [3:0] seg_hi, seg_lo;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] m_mem [16];
  logic [1:0] m_mode;
  logic [3:0] m_ptr;
  logic       m_ai, m_ihi, m_ilo, m_bhi, m_blo;

  always #(CLK_PERIOD / 2) clk = ~clk;

  disp_refresh_ctrl #(.SCAN_DIV(SCAN_DIV)) u0 (.*);

  function automatic logic [3:0] m_last();
    return m_mode[0] ? 4'd15 : 4'd7;
  endfunction

  function automatic logic [7:0] m_merge(logic [7:0] old_v, logic [7:0] new_v);
    return {m_ihi ? old_v[7:4] : new_v[7:4], m_ilo ? old_v[3:0] : new_v[3:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic beat(logic [1:0] k, logic [7:0] b);
    in_valid = 1'b1; in_kind = k; in_byte = b;
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic cmd(logic [7:0] b);
    beat(2'b00, b);
    case (b[7:5])
      3'b000: m_mode = b[1:0];
      3'b100: begin m_ptr = b[3:0]; m_ai = b[4]; end
      3'b101: {m_ihi, m_ilo, m_bhi, m_blo} = b[3:0];
      3'b110: begin for (int i = 0; i < 16; i++) m_mem[i] = 8'h00; m_ptr = 4'd0; end
      default: ;
    endcase
  endtask

  task automatic wr(logic [7:0] b);
    logic [3:0] l, e;
    beat(2'b01, b);
    l = m_last();
    e = m_ptr & l;
    if (m_mode[1]) begin
      logic [7:0] nv;
      nv = m_merge(m_mem[l], b);
      for (int i = 0; i < 15; i++) if (i < l) m_mem[i] = m_mem[i + 1];
      m_mem[l] = nv;
    end else begin
      m_mem[e] = m_merge(m_mem[e], b);
      if (m_ai) m_ptr = (e + 4'd1) & l;
    end
  endtask

  task automatic rd(string req);
    logic [3:0] e;
    beat(2'b10, 8'h00);
    e = m_ptr & m_last();
    check(req, {rd_valid, rd_data}, {1'b1, m_mem[e]});
    if (m_ai) m_ptr = (e + 4'd1) & m_last();
    rd_ready = 1'b1;
    @(posedge clk); #1;
    rd_ready = 1'b0;
    @(negedge clk);
    check(req, {rd_valid, in_ready}, {1'b0, 1'b1});
  endtask

  task automatic check_disp(string req);
    logic [7:0] v;
    v = m_mem[scan_idx];
    check(req, {seg_hi, seg_lo},
          {(disp_blank || m_bhi) ? 4'h0 : v[7:4], (disp_blank || m_blo) ? 4'h0 : v[3:0]});
  endtask

  task automatic dump_check(string req);
    logic [3:0] n;
    n = m_last();
    cmd(8'h90);
    for (int i = 0; i < 16; i++) if (i <= n) rd(req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 16; i++) m_mem[i] = 8'h00;
    m_mode = 2'b00; m_ptr = 4'd0;
    {m_ai, m_ihi, m_ilo, m_bhi, m_blo} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state (one cycle after release)
    check("R1", {rd_valid, in_ready, seg_hi, seg_lo}, {1'b0, 1'b1, 8'h00});
    check("R1", {28'h0, scan_idx}, 32'd0);

    // R3 left entry, 16 digits, auto-increment, pointer wrap
    cmd(8'h01);
    cmd(8'h9E);
    for (int i = 0; i < 4; i++) wr(8'hA0 + 8'(i));
    cmd(8'h8E); rd("R3"); rd("R3");
    cmd(8'h80); rd("R3");
    check("R3", {24'h0, m_mem[0]}, 32'hA2);
    cmd(8'h00); cmd(8'h9F); wr(8'h5C);
    cmd(8'h87); rd("R3");
    check("R3", {24'h0, m_mem[7]}, 32'h5C);

    // R4 right entry, 8 digits
    cmd(8'hC0); cmd(8'h02);
    wr(8'h11); wr(8'h22); wr(8'h33);
    check("R4", {m_mem[5], m_mem[6], m_mem[7]}, 24'h112233);
    dump_check("R4");
    cmd(8'h03); wr(8'h44);
    check("R4", {m_mem[14], m_mem[15]}, 16'h0044);
    cmd(8'h01); dump_check("R4");

    // R5 write protection per nibble
    cmd(8'h00); cmd(8'h83); cmd(8'hA8); wr(8'hFF);
    cmd(8'hA4); cmd(8'h84); wr(8'hEE);
    cmd(8'hA0); dump_check("R5");

    // R6 back-pressure: held result, blocked input
    cmd(8'h85);
    in_valid = 1'b1; in_kind = 2'b10;
    @(posedge clk); #1;
    in_kind = 2'b01; in_byte = 8'h77;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6", {rd_valid, in_ready, rd_data}, {1'b1, 1'b0, m_mem[5]});
    in_valid = 1'b0; rd_ready = 1'b1;
    @(posedge clk); #1; rd_ready = 1'b0; @(negedge clk);
    check("R6", {31'h0, rd_valid}, 32'd0);
    cmd(8'h85); rd("R6");

    // R9 nibble blanking
    cmd(8'h80); wr(8'h9D);
    cmd(8'hA2);
    for (int i = 0; i < 20; i++) begin check("R9", {28'h0, seg_hi}, 32'h0); check_disp("R9"); @(negedge clk); end
    cmd(8'hA1);
    for (int i = 0; i < 20; i++) begin check("R9", {28'h0, seg_lo}, 32'h0); check_disp("R9"); @(negedge clk); end
    cmd(8'hA0);

    // R11 undefined opcodes and kind 11 change nothing
    cmd(8'h83); cmd(8'h3F); cmd(8'h5F); cmd(8'h6F); cmd(8'hFF);
    beat(2'b11, 8'h00);
    in_valid = 1'b1; in_kind = 2'b11; in_byte = 8'h42; @(posedge clk); #1; in_valid = 1'b0; @(negedge clk);
    dump_check("R11");

    // R7 / R8 scan slots in 8 then 16 digit mode
    for (int md = 0; md < 2; md++) begin
      int since, seen_changes, maxi;
      logic [3:0] prev;
      cmd(md == 0 ? 8'h00 : 8'h01);
      prev = scan_idx; since = 0; seen_changes = 0; maxi = 0;
      for (int c = 0; c < 3 * 16 * SCAN_DIV; c++) begin
        @(negedge clk);
        since++;
        if (scan_idx != prev) begin
          if (seen_changes > 0) begin
            check("R7", since, SCAN_DIV);
            check("R7", {28'h0, scan_idx}, (prev == (md == 0 ? 4'd7 : 4'd15)) ? 32'd0 : 32'(prev) + 1);
          end
          check("R8", {31'h0, disp_blank}, 32'd1);
          seen_changes++; since = 0;
        end else if (seen_changes > 0) begin
          check("R8", {31'h0, disp_blank}, 32'd0);
        end
        if (seen_changes > 0 && int'(scan_idx) > maxi) maxi = int'(scan_idx);
        check_disp("R8");
        prev = scan_idx;
      end
      check("R7", maxi, md == 0 ? 7 : 15);
    end

    // R10 clear
    cmd(8'h01); cmd(8'h8A); wr(8'h6B);
    cmd(8'hC0);
    check("R10", {24'h0, m_mem[10]}, 32'h0);
    dump_check("R10");

    // R2 random mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 4) wr(8'($urandom));
      else if (r < 6) rd("R2");
      else if (r == 6) cmd({3'b100, 5'($urandom)});
      else if (r == 7) cmd({3'b000, 3'b000, 2'($urandom)});
      else if (r == 8) cmd({3'b101, 1'b0, 4'($urandom) & 4'hC});
      else cmd({3'($urandom_range(0, 7)) == 3'b110 ? 3'b111 : 3'($urandom_range(0, 7)), 5'($urandom)});
      check_disp("R2");
    end
    cmd(8'hA0); dump_check("R2");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule